// File: doc/BRIEF.md
# Strap-Pin Mode Configuration Controller

This block is the digital configuration front end of a multichannel simultaneous-sampling converter. While a full reset is held it watches a set of strap pins. On the first clock edge after the reset is released, it freezes the operating configuration. That configuration covers three things: whether the device is driven by its register file (software mode) or by its pins (hardware mode), which host interface is used (parallel, byte-wide or serial), and which feature enables apply. The frozen configuration also decides how each shared pin is routed, for example whether the write/burst line is a write strobe or a burst enable. One clock cycle after the freeze, a single `cfg_valid_o` pulse announces that every latched field is stable.

In hardware mode two groups of pins stay live after the freeze. The range-select pins set the analog range of all channels at once, and every change starts a settling interval that is reported on `settle_pending_o`. The channel-select pins give the first channel pair at reset release. After that they are sampled again at the end of each conversion window, which opens on a conversion-start rising edge and closes on a busy falling edge, to choose the next pair. All strap and select pins pass through multi-flop synchronizers. The conversion-start and busy inputs come from the converter core and are synchronous.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: At the first clock edge with `rst` low after a full reset, the synchronized range-select value 00 selects software mode (`hw_mode_o`=0). Any other value selects hardware mode (`hw_mode_o`=1).
- R2: `ifc_mode_o` is latched from the interface straps with this encoding: 2'b00 parallel when `ifc_ser_i`=0; 2'b01 serial when `ifc_ser_i`=1 and `ifc_bsel_i`=0; 2'b10 byte when both are 1.
- R3: `crc_en_o` and `os_ratio_o` take their strap values only in hardware serial mode, and are 0 otherwise. `burst_en_o` takes the write/burst strap in every hardware interface and is 0 in software mode.
- R4: After release, changes on any strap pin leave `hw_mode_o`, `ifc_mode_o`, `seq_en_o`, `ref_sel_o`, `crc_en_o`, `burst_en_o`, `os_ratio_o` and `one_wire_o` unchanged until the next full reset.
- R5: `wr_strobe_o` follows the write/burst pin, two clock edges late, only in software byte or parallel mode. It stays 0 in software serial mode, in hardware mode and during reset.
- R6: `one_wire_o` takes the one-wire strap in software serial and hardware serial modes, and is 0 in byte and parallel modes.
- R7: While `rst` is high, `cfg_valid_o`, `hw_mode_o` and `settle_pending_o` are 0. After release, `cfg_valid_o` is high for exactly one cycle, the cycle after the capture edge.
- R8: `next_pair_o` is loaded with the synchronized channel-select value at the capture edge, in both modes.
- R9: In hardware mode, `next_pair_o` is reloaded from the synchronized channel-select value on the busy falling edge that follows a conversion-start rising edge. A busy fall with no preceding conversion start does not change it, and in software mode it never changes after capture.
- R10: In hardware mode, `range_o` follows the range-select pins two edges after they change. In software mode it is 00. A change to 00 during hardware mode is only a range change, and `hw_mode_o` stays 1.
- R11: Each hardware-mode range change restarts a settle count of CLK_HZ/1e6 × SETTLE_US cycles (12000 at the defaults). `settle_pending_o` is high for exactly that many cycles after the last change.
- R12: `seq_en_o` takes the sequencer strap in hardware mode and is 0 in software mode. `ref_sel_o` takes the reference strap in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| rng_sel_i | input | 2 | Range-select pins; mode strap at reset release |
| ifc_ser_i | input | 1 | Interface strap: 0 parallel, 1 serial or byte |
| ifc_bsel_i | input | 1 | Interface strap: byte select when serial strap is 1 |
| seq_en_i | input | 1 | Sequencer enable strap |
| ref_sel_i | input | 1 | Reference select strap |
| crc_pin_i | input | 1 | Shared data-bit-5 pin, CRC enable strap |
| os_pin_i | input | 3 | Shared data-bits-15:13 pins, oversampling strap |
| wr_burst_i | input | 1 | Shared write/burst pin |
| one_wire_pin_i | input | 1 | Shared data-bit-4 pin, one-wire serial strap |
| chan_sel_i | input | 3 | Channel-pair select pins |
| conv_start_i | input | 1 | Conversion start from converter core |
| busy_i | input | 1 | Conversion busy from converter core |
| cfg_valid_o | output | 1 | One-cycle pulse when configuration is stable |
| hw_mode_o | output | 1 | 1 hardware mode, 0 software mode |
| ifc_mode_o | output | 2 | Latched interface encoding |
| seq_en_o | output | 1 | Latched sequencer enable |
| ref_sel_o | output | 1 | Latched reference select |
| crc_en_o | output | 1 | Latched CRC enable |
| burst_en_o | output | 1 | Latched burst enable |
| os_ratio_o | output | 3 | Latched oversampling code |
| one_wire_o | output | 1 | Latched one-wire serial select |
| wr_strobe_o | output | 1 | Routed write strobe |
| range_o | output | 2 | Live range code in hardware mode |
| next_pair_o | output | 3 | Next channel pair to convert |
| settle_pending_o | output | 1 | High while range settling runs |

## Verification
A range change and a channel-pair reload can land on the same clock edge, because they come from independent pins and independent edge detectors. The bench provokes this by timing a range-pin change so that it is synchronized and detected on the same edge as a busy falling edge inside an open conversion window. It then checks that the new pair, the new range and a fresh, full-length settle count all appear together. A second overlap is a range change during an already running settle interval, which is judged by the total pending length.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

    localparam int RNG_W = 2;
    localparam int OS_W  = 3;
    localparam int CH_W  = 3;

    typedef enum logic [1:0] {
        IFC_PAR  = 2'b00,
        IFC_SER  = 2'b01,
        IFC_BYTE = 2'b10
    } ifc_e;

    typedef enum logic [1:0] {
        ST_HOLD     = 2'd0,
        ST_ANNOUNCE = 2'd1,
        ST_RUN      = 2'd2
    } cap_state_e;

    // Raw or synchronized pin bundle
    typedef struct packed {
        logic [RNG_W-1:0] rng;
        logic             ser;
        logic             bsel;
        logic             seq_en;
        logic             ref_sel;
        logic             crc_pin;
        logic [OS_W-1:0]  os_pin;
        logic             wb_pin;
        logic             one_wire_pin;
        logic [CH_W-1:0]  chan;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);

    // Frozen configuration
    typedef struct packed {
        logic            hw;
        ifc_e            ifc;
        logic            seq_en;
        logic            ref_sel;
        logic            crc_en;
        logic            burst_en;
        logic [OS_W-1:0] os;
        logic            one_wire;
    } cfg_t;

    function automatic ifc_e decode_ifc(input logic ser, input logic bsel);
        if (!ser)      return IFC_PAR;
        else if (bsel) return IFC_BYTE;
        else           return IFC_SER;
    endfunction

    function automatic cfg_t build_cfg(input strap_t s);
        cfg_t c;
        logic hw_ser;
        c.hw       = |s.rng;
        c.ifc      = decode_ifc(s.ser, s.bsel);
        hw_ser     = c.hw && (c.ifc == IFC_SER);
        c.seq_en   = c.hw & s.seq_en;
        c.ref_sel  = s.ref_sel;
        c.crc_en   = hw_ser & s.crc_pin;
        c.os       = hw_ser ? s.os_pin : '0;
        c.burst_en = c.hw & s.wb_pin;
        c.one_wire = (c.ifc == IFC_SER) & s.one_wire_pin;
        return c;
    endfunction

    // Write/burst pin acts as a write strobe only in software byte/parallel
    function automatic logic wr_routed(input cfg_t c);
        return !c.hw && (c.ifc != IFC_SER);
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) stage_q[0] <= d_i;

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) stage_q[g] <= stage_q[g-1];
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_capture.sv
module cfg_capture
    import strap_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_next_i,
    output cfg_t cfg_o,
    output logic capture_o,
    output logic live_o,
    output logic valid_o
);
    cap_state_e state_q;
    cfg_t       cfg_q;

    assign capture_o = (state_q == ST_HOLD) && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            cfg_q   <= '0;
        end else begin
            case (state_q)
                ST_HOLD: begin
                    cfg_q   <= cfg_next_i;
                    state_q <= ST_ANNOUNCE;
                end
                ST_ANNOUNCE: state_q <= ST_RUN;
                default:     state_q <= ST_RUN;
            endcase
        end
    end

    assign cfg_o   = cfg_q;
    assign live_o  = (state_q != ST_HOLD);
    assign valid_o = (state_q == ST_ANNOUNCE);

    // R4: configuration never moves once captured
    p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_HOLD) |=> $stable(cfg_q));

    // R7: announcement lasts a single cycle
    p_valid_once_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
endmodule

// File: rtl/range_settle.sv
module range_settle
    import strap_cfg_pkg::*;
#(
    parameter int SETTLE_CYCLES = 12000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             live_i,
    input  logic             hw_i,
    input  logic [RNG_W-1:0] rng_i,
    output logic [RNG_W-1:0] range_o,
    output logic             pending_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES);

    logic [RNG_W-1:0] prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             changed;

    assign changed = live_i && hw_i && (rng_i != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else begin
            prev_q <= rng_i;
            if (changed)          cnt_q <= LOAD;
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign range_o   = hw_i ? rng_i : '0;
    assign pending_o = (cnt_q != '0);

    // R11: a detected change reloads the full interval
    p_settle_load_r11: assert property (@(posedge clk) disable iff (rst)
        changed |=> (cnt_q == LOAD));

    // R11: otherwise the interval counts down by one per cycle
    p_settle_step_r11: assert property (@(posedge clk) disable iff (rst)
        (pending_o && !changed) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pair_select.sv
module pair_select
    import strap_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            capture_i,
    input  logic            live_i,
    input  logic            hw_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            conv_start_i,
    input  logic            busy_i,
    output logic [CH_W-1:0] pair_o
);
    logic            conv_q, busy_q, window_q;
    logic [CH_W-1:0] pair_q;
    logic            conv_rise, busy_fall, reload;

    assign conv_rise = conv_start_i & ~conv_q;
    assign busy_fall = busy_q & ~busy_i;
    assign reload    = live_i && hw_i && window_q && busy_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_q   <= 1'b0;
            busy_q   <= 1'b0;
            window_q <= 1'b0;
            pair_q   <= '0;
        end else begin
            conv_q <= conv_start_i;
            busy_q <= busy_i;
            if (capture_i) begin
                pair_q <= chan_i;
            end else if (reload) begin
                pair_q   <= chan_i;
                window_q <= 1'b0;
            end else if (live_i && hw_i && conv_rise) begin
                window_q <= 1'b1;
            end
        end
    end

    assign pair_o = pair_q;

    // R9: the pair only moves at a window close
    p_pair_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (live_i && !reload) |=> $stable(pair_q));

    // R9: software mode never opens a window
    p_sw_no_window_r9: assert property (@(posedge clk) disable iff (rst)
        (live_i && !hw_i) |-> !window_q);
endmodule

// File: rtl/strap_cfg_ctrl.sv
module strap_cfg_ctrl
    import strap_cfg_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int SETTLE_US   = 120,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rng_sel_i,
    input  logic       ifc_ser_i,
    input  logic       ifc_bsel_i,
    input  logic       seq_en_i,
    input  logic       ref_sel_i,
    input  logic       crc_pin_i,
    input  logic [2:0] os_pin_i,
    input  logic       wr_burst_i,
    input  logic       one_wire_pin_i,
    input  logic [2:0] chan_sel_i,
    input  logic       conv_start_i,
    input  logic       busy_i,
    output logic       cfg_valid_o,
    output logic       hw_mode_o,
    output logic [1:0] ifc_mode_o,
    output logic       seq_en_o,
    output logic       ref_sel_o,
    output logic       crc_en_o,
    output logic       burst_en_o,
    output logic [2:0] os_ratio_o,
    output logic       one_wire_o,
    output logic       wr_strobe_o,
    output logic [1:0] range_o,
    output logic [2:0] next_pair_o,
    output logic       settle_pending_o
);
    localparam int SETTLE_CYCLES = (CLK_HZ / 1000) * SETTLE_US / 1000;

    strap_t pins_raw, pins_s;
    cfg_t   cfg_next, cfg;
    logic   capture, live;

    assign pins_raw = '{rng: rng_sel_i, ser: ifc_ser_i, bsel: ifc_bsel_i,
                        seq_en: seq_en_i, ref_sel: ref_sel_i, crc_pin: crc_pin_i,
                        os_pin: os_pin_i, wb_pin: wr_burst_i,
                        one_wire_pin: one_wire_pin_i, chan: chan_sel_i};

    strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (pins_raw),
        .q_o (pins_s)
    );

    assign cfg_next = build_cfg(pins_s);

    cfg_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .cfg_next_i (cfg_next),
        .cfg_o      (cfg),
        .capture_o  (capture),
        .live_o     (live),
        .valid_o    (cfg_valid_o)
    );

    range_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_rng (
        .clk       (clk),
        .rst       (rst),
        .live_i    (live),
        .hw_i      (cfg.hw),
        .rng_i     (pins_s.rng),
        .range_o   (range_o),
        .pending_o (settle_pending_o)
    );

    pair_select u_pair (
        .clk          (clk),
        .rst          (rst),
        .capture_i    (capture),
        .live_i       (live),
        .hw_i         (cfg.hw),
        .chan_i       (pins_s.chan),
        .conv_start_i (conv_start_i),
        .busy_i       (busy_i),
        .pair_o       (next_pair_o)
    );

    assign hw_mode_o   = cfg.hw;
    assign ifc_mode_o  = cfg.ifc;
    assign seq_en_o    = cfg.seq_en;
    assign ref_sel_o   = cfg.ref_sel;
    assign crc_en_o    = cfg.crc_en;
    assign burst_en_o  = cfg.burst_en;
    assign os_ratio_o  = cfg.os;
    assign one_wire_o  = cfg.one_wire;
    assign wr_strobe_o = live && wr_routed(cfg) && pins_s.wb_pin;

    // R10: software mode has no live range and no settling
    p_sw_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !hw_mode_o |-> (!settle_pending_o && range_o == 2'b00));
endmodule

// File: tb/sim_strap_cfg_ctrl.sv
module sim_strap_cfg_ctrl;
    localparam int SETTLE_N = (100_000_000 / 1000) * 120 / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rng_sel = 2'b00;
    logic       ifc_ser = 1'b0, ifc_bsel = 1'b0, seq_en = 1'b0, ref_sel = 1'b0;
    logic       crc_pin = 1'b0, wr_burst = 1'b0, one_wire_pin = 1'b0;
    logic [2:0] os_pin = 3'd0, chan_sel = 3'd0;
    logic       conv_start = 1'b0, busy = 1'b0;

    logic       cfg_valid, hw_mode, seq_en_q, ref_sel_q, crc_en, burst_en, one_wire, wr_strobe, settle_pending;
    logic [1:0] ifc_mode, range_q;
    logic [2:0] os_ratio, next_pair;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    strap_cfg_ctrl u0 (
        .clk(clk), .rst(rst), .rng_sel_i(rng_sel), .ifc_ser_i(ifc_ser), .ifc_bsel_i(ifc_bsel),
        .seq_en_i(seq_en), .ref_sel_i(ref_sel), .crc_pin_i(crc_pin), .os_pin_i(os_pin),
        .wr_burst_i(wr_burst), .one_wire_pin_i(one_wire_pin), .chan_sel_i(chan_sel),
        .conv_start_i(conv_start), .busy_i(busy), .cfg_valid_o(cfg_valid), .hw_mode_o(hw_mode),
        .ifc_mode_o(ifc_mode), .seq_en_o(seq_en_q), .ref_sel_o(ref_sel_q), .crc_en_o(crc_en),
        .burst_en_o(burst_en), .os_ratio_o(os_ratio), .one_wire_o(one_wire), .wr_strobe_o(wr_strobe),
        .range_o(range_q), .next_pair_o(next_pair), .settle_pending_o(settle_pending)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_straps(input logic [1:0] r, input logic s, input logic b, input logic sq,
                              input logic rf, input logic c, input logic [2:0] o,
                              input logic wb, input logic ow, input logic [2:0] ch);
        rng_sel = r; ifc_ser = s; ifc_bsel = b; seq_en = sq; ref_sel = rf;
        crc_pin = c; os_pin = o; wr_burst = wb; one_wire_pin = ow; chan_sel = ch;
    endtask

    // Hold reset, check reset outputs, release, check the valid pulse
    task automatic full_reset();
        @(negedge clk) rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 valid in reset", cfg_valid, 0);
        chk("R7 hw in reset", hw_mode, 0);
        chk("R7 settle in reset", settle_pending, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 valid pulse", cfg_valid, 1);
        @(negedge clk);
        chk("R7 valid drops", cfg_valid, 0);
    endtask

    task automatic conv_cycle(input bit with_start, input logic [2:0] ch);
        @(negedge clk) conv_start = with_start; busy = 1'b1; chan_sel = ch;
        @(negedge clk) conv_start = 1'b0;
        repeat (3) @(negedge clk);
        busy = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_sw_parallel();
        set_straps(2'b00, 0, 0, 1, 1, 1, 3'd5, 0, 1, 3'd5);
        full_reset();
        chk("R1 sw mode", hw_mode, 0);
        chk("R2 parallel", ifc_mode, 0);
        chk("R3 crc sw", crc_en, 0);
        chk("R3 os sw", os_ratio, 0);
        chk("R3 burst sw", burst_en, 0);
        chk("R12 seq sw", seq_en_q, 0);
        chk("R12 ref sw", ref_sel_q, 1);
        chk("R6 onewire parallel", one_wire, 0);
        chk("R8 initial pair", next_pair, 5);
        @(negedge clk) wr_burst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 strobe high", wr_strobe, 1);
        wr_burst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 strobe low", wr_strobe, 0);
        rng_sel = 2'b10;
        repeat (4) @(negedge clk);
        chk("R10 sw range", range_q, 0);
        chk("R10 sw no settle", settle_pending, 0);
        chk("R1 sw stays sw", hw_mode, 0);
        conv_cycle(1, 3'd2);
        chk("R9 sw pair fixed", next_pair, 5);
    endtask

    task automatic t_sw_serial();
        set_straps(2'b00, 1, 0, 0, 0, 0, 3'd0, 1, 1, 3'd1);
        full_reset();
        chk("R2 serial", ifc_mode, 1);
        chk("R6 onewire sw serial", one_wire, 1);
        repeat (2) @(negedge clk);
        chk("R5 strobe ignored sw serial", wr_strobe, 0);
        chk("R3 burst sw serial", burst_en, 0);
    endtask

    task automatic t_hw_serial();
        set_straps(2'b01, 1, 0, 1, 0, 1, 3'd6, 1, 1, 3'd2);
        full_reset();
        chk("R1 hw mode", hw_mode, 1);
        chk("R2 hw serial", ifc_mode, 1);
        chk("R3 crc hw serial", crc_en, 1);
        chk("R3 os hw serial", os_ratio, 6);
        chk("R3 burst hw serial", burst_en, 1);
        chk("R12 seq hw", seq_en_q, 1);
        chk("R12 ref hw", ref_sel_q, 0);
        chk("R6 onewire hw serial", one_wire, 1);
        chk("R10 range follows", range_q, 1);
        chk("R8 initial pair hw", next_pair, 2);
        chk("R5 strobe off hw", wr_strobe, 0);
        @(negedge clk);
        ifc_ser = 0; ifc_bsel = 1; seq_en = 0; ref_sel = 1; crc_pin = 0;
        os_pin = 3'd1; wr_burst = 0; one_wire_pin = 0;
        repeat (6) @(negedge clk);
        chk("R4 hw frozen", hw_mode, 1);
        chk("R4 ifc frozen", ifc_mode, 1);
        chk("R4 crc frozen", crc_en, 1);
        chk("R4 os frozen", os_ratio, 6);
        chk("R4 burst frozen", burst_en, 1);
        chk("R4 seq frozen", seq_en_q, 1);
        chk("R4 ref frozen", ref_sel_q, 0);
        chk("R4 onewire frozen", one_wire, 1);
    endtask

    task automatic t_hw_byte();
        set_straps(2'b10, 1, 1, 0, 1, 1, 3'd6, 1, 1, 3'd0);
        full_reset();
        chk("R2 byte", ifc_mode, 2);
        chk("R3 crc hw byte", crc_en, 0);
        chk("R3 os hw byte", os_ratio, 0);
        chk("R3 burst hw byte", burst_en, 1);
        chk("R6 onewire byte", one_wire, 0);
        chk("R5 strobe off hw byte", wr_strobe, 0);
    endtask

    task automatic t_hw_parallel_channel();
        set_straps(2'b11, 0, 0, 0, 0, 1, 3'd7, 1, 0, 3'd3);
        full_reset();
        chk("R2 hw parallel", ifc_mode, 0);
        chk("R3 burst hw parallel", burst_en, 1);
        chk("R3 crc hw parallel", crc_en, 0);
        chk("R8 initial pair", next_pair, 3);
        conv_cycle(1, 3'd6);
        chk("R9 reload at busy fall", next_pair, 6);
        conv_cycle(0, 3'd1);
        chk("R9 no start no reload", next_pair, 6);
    endtask

    task automatic t_settle();
        int cnt = 0;
        @(negedge clk) rng_sel = 2'b01;
        for (int i = 0; i < SETTLE_N + 200; i++) begin
            @(negedge clk);
            if (settle_pending) cnt++;
        end
        chk("R11 settle length", cnt, SETTLE_N);
        chk("R10 range now 1", range_q, 1);
        cnt = 0;
        rng_sel = 2'b00;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (settle_pending) cnt++;
            if (i == 3) begin
                chk("R10 zero range stays hw", hw_mode, 1);
                chk("R10 zero range", range_q, 0);
            end
        end
        rng_sel = 2'b10;
        for (int i = 0; i < SETTLE_N + 200; i++) begin
            @(negedge clk);
            if (settle_pending) cnt++;
        end
        chk("R11 restart length", cnt, SETTLE_N + 100);
        chk("R10 range now 2", range_q, 2);
    endtask

    // Range change and pair reload on the same edge
    task automatic t_same_cycle();
        int cnt = 0;
        @(negedge clk) chan_sel = 3'd4;
        repeat (3) @(negedge clk);
        conv_start = 1'b1; busy = 1'b1;
        @(negedge clk) conv_start = 1'b0;
        repeat (2) @(negedge clk);
        rng_sel = 2'b01;
        repeat (2) @(negedge clk);
        busy = 1'b0;
        @(negedge clk);
        chk("R9 pair with range change", next_pair, 4);
        chk("R10 range with reload", range_q, 1);
        chk("R11 settle with reload", settle_pending, 1);
        if (settle_pending) cnt++;
        for (int i = 0; i < SETTLE_N + 50; i++) begin
            @(negedge clk);
            if (settle_pending) cnt++;
        end
        chk("R11 settle length coincident", cnt, SETTLE_N);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1-all actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_sw_parallel();
        t_sw_serial();
        t_hw_serial();
        t_hw_byte();
        t_hw_parallel_channel();
        t_settle();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule